// File: doc/BRIEF.md
# Constant-Fraction Waveform Timer

This block receives one channel's stored waveform as a stream of 12-bit ADC codes and extracts the arrival time of the pulse in it. It keeps the record in a local buffer. It estimates the pedestal from the opening samples and finds the highest sample. It then sets a crossing level at a programmable fraction of the pedestal-corrected peak. Because the level scales with the pulse, the extracted time does not shift with pulse height.

The leading-edge crossing is found by walking backwards from the peak to the first sample under the level. The time is then refined to 1/256 of a sample by linear interpolation between that sample and its successor. A small restoring divider performs the interpolation over several cycles.

A run starts with a start pulse while the block is ready. Exactly `DEPTH` samples follow, each qualified by a valid strobe. The block answers with a one-cycle done pulse that carries the peak amplitude, the peak index and either a valid time or an error.

Top module: `cfd_timer`

## Requirements
- R1: After reset, ready_o is 1 and done_o, time_valid_o and err_o are 0.
- R2: The baseline is floor(sum of samples 0..15 / 16). amp_o is the maximum sample minus the baseline.
- R3: peak_idx_o is the lowest index that holds the maximum sample.
- R4: The crossing level is baseline + floor(amp * k / 256), with k the 8-bit k_i captured at the accepted start.
- R5: The crossing index i is the largest index below the peak with s[i] < level. time_o = i*256 + floor((level - s[i])*256 / (s[i+1] - s[i])), so the low 8 bits are the fraction and a fraction of exactly one is allowed.
- R6: If amp < min_amp_i (captured at start), or no index below the peak qualifies (including a peak at index 0), then err_o=1, time_valid_o=0 and time_o=0 at done. Otherwise err_o=0 and time_valid_o=1.
- R7: done_o is a one-cycle pulse. Counting clock edges after the edge that accepts the last sample, done_o rises after edge 1 for an amplitude or peak-at-0 error, after edge 1+peak for a missing crossing, and after edge 11+(peak-i) on success.
- R8: start_i is ignored while ready_o is 0. ready_o falls after an accepted start and returns together with done_o.
- R9: Only cycles with sample_vld_i high load a sample, so gaps in the stream do not change the result. The result outputs change only on the cycle done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | begin a new waveform when ready |
| k_i | input | 8 | fraction numerator, k/256 |
| min_amp_i | input | 12 | minimum accepted amplitude |
| sample_i | input | 12 | ADC sample |
| sample_vld_i | input | 1 | sample qualifier |
| ready_o | output | 1 | idle, start accepted |
| done_o | output | 1 | result pulse |
| time_valid_o | output | 1 | time_o holds a crossing time |
| err_o | output | 1 | no usable crossing |
| amp_o | output | 12 | baseline-corrected peak amplitude |
| peak_idx_o | output | 10 | index of the peak sample |
| time_o | output | 18 | crossing time, 8 fractional bits |

## Verification
A wrong baseline or peak register shows at amp_o and peak_idx_o on the very next done pulse. A wrong level or bracket index also moves the done cycle, because the backward walk takes one cycle per sample. Comparing done_o on every clock against the model therefore catches most control faults within a few cycles of the point where the model and the design diverge. A divider fault shows only in the low eight bits of time_o, and these are compared exactly.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CALC,
    ST_SCAN,
    ST_DIV
  } cfd_state_e;
endpackage

// File: rtl/cfd_wave_buf.sv
module cfd_wave_buf #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cfd_peak_track.sv
module cfd_peak_track #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 1024,
  parameter int BASE_N = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BASE_SH = $clog2(BASE_N),
  localparam int SUM_W  = DATA_W + BASE_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] base_o,
  output logic [DATA_W-1:0] max_o,
  output logic [IDX_W-1:0]  max_idx_o
);
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q     <= '0;
      max_o     <= '0;
      max_idx_o <= '0;
    end else if (clr_i) begin
      sum_q     <= '0;
      max_o     <= '0;
      max_idx_o <= '0;
    end else if (push_i) begin
      if (32'(idx_i) < BASE_N) sum_q <= sum_q + SUM_W'(data_i);
      // strict compare keeps the first of equal maxima
      if (idx_i == '0 || data_i > max_o) begin
        max_o     <= data_i;
        max_idx_o <= idx_i;
      end
    end
  end

  assign base_o = sum_q[SUM_W-1:BASE_SH];
endmodule

// File: rtl/cfd_frac_div.sv
module cfd_frac_div #(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 8,
  localparam int Q_W   = FRAC_W + 1,
  localparam int CNT_W = $clog2(FRAC_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] num_i,  // num_i <= den_i
  input  logic [DATA_W-1:0] den_i,
  output logic              done_o,
  output logic [Q_W-1:0]    q_o
);
  logic [DATA_W:0]   r_q;
  logic [DATA_W-1:0] den_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;
  logic              ge;
  logic [DATA_W:0]   rem;

  assign ge  = r_q >= {1'b0, den_q};
  assign rem = ge ? r_q - {1'b0, den_q} : r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q    <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      q_o    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (ld_i) begin
        r_q   <= {1'b0, num_i};
        den_q <= den_i;
        cnt_q <= '0;
        q_o   <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        q_o   <= {q_o[Q_W-2:0], ge};
        r_q   <= {rem[DATA_W-1:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(FRAC_W)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfd_timer.sv
module cfd_timer #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 1024,
  parameter int BASE_N = 16,
  parameter int K_W    = 8,
  parameter int FRAC_W = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int TIME_W = IDX_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [K_W-1:0]    k_i,
  input  logic [DATA_W-1:0] min_amp_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_vld_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              time_valid_o,
  output logic              err_o,
  output logic [DATA_W-1:0] amp_o,
  output logic [IDX_W-1:0]  peak_idx_o,
  output logic [TIME_W-1:0] time_o
);
  import cfd_pkg::*;

  cfd_state_e        state_q;
  logic [IDX_W-1:0]  wr_idx_q, scan_idx_q;
  logic [DATA_W-1:0] s_prev_q, thr_q, amp_q, min_q;
  logic [K_W-1:0]    k_q;
  logic [IDX_W-1:0]  peak_q;

  logic              accept, push, trk_clr;
  logic [DATA_W-1:0] base, pk_max, rd_data;
  logic [IDX_W-1:0]  pk_idx;
  logic [DATA_W-1:0] amp_c, thr_c;
  logic [DATA_W+K_W-1:0] prod_c;
  logic              below, div_ld, div_done;
  logic [FRAC_W:0]   div_q;

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign trk_clr = accept;
  assign push    = (state_q == ST_LOAD) && sample_vld_i;
  assign ready_o = (state_q == ST_IDLE);

  cfd_wave_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk_i, .we_i(push), .waddr_i(wr_idx_q), .wdata_i(sample_i),
    .raddr_i(scan_idx_q), .rdata_o(rd_data)
  );

  cfd_peak_track #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BASE_N(BASE_N)) u_trk (
    .clk_i, .rst_ni, .clr_i(trk_clr), .push_i(push), .idx_i(wr_idx_q),
    .data_i(sample_i), .base_o(base), .max_o(pk_max), .max_idx_o(pk_idx)
  );

  // level = base + amp*k/2^K_W, never above the peak
  assign amp_c  = pk_max - base;
  assign prod_c = amp_c * k_q;
  assign thr_c  = base + prod_c[DATA_W+K_W-1:K_W];

  assign below  = rd_data < thr_q;
  assign div_ld = (state_q == ST_SCAN) && below;

  cfd_frac_div #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_div (
    .clk_i, .rst_ni, .ld_i(div_ld), .num_i(thr_q - rd_data),
    .den_i(s_prev_q - rd_data), .done_o(div_done), .q_o(div_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      wr_idx_q     <= '0;
      scan_idx_q   <= '0;
      s_prev_q     <= '0;
      thr_q        <= '0;
      amp_q        <= '0;
      min_q        <= '0;
      k_q          <= '0;
      peak_q       <= '0;
      done_o       <= 1'b0;
      time_valid_o <= 1'b0;
      err_o        <= 1'b0;
      amp_o        <= '0;
      peak_idx_o   <= '0;
      time_o       <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          k_q      <= k_i;
          min_q    <= min_amp_i;
          wr_idx_q <= '0;
          state_q  <= ST_LOAD;
        end
        ST_LOAD: if (sample_vld_i) begin
          wr_idx_q <= wr_idx_q + 1'b1;
          if (wr_idx_q == IDX_W'(DEPTH - 1)) state_q <= ST_CALC;
        end
        ST_CALC: begin
          amp_q      <= amp_c;
          peak_q     <= pk_idx;
          thr_q      <= thr_c;
          s_prev_q   <= pk_max;
          scan_idx_q <= pk_idx - 1'b1;
          if (amp_c < min_q || pk_idx == '0) begin
            done_o <= 1'b1; err_o <= 1'b1; time_valid_o <= 1'b0;
            time_o <= '0; amp_o <= amp_c; peak_idx_o <= pk_idx;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (below) begin
            state_q <= ST_DIV;
          end else if (scan_idx_q == '0) begin
            done_o <= 1'b1; err_o <= 1'b1; time_valid_o <= 1'b0;
            time_o <= '0; amp_o <= amp_q; peak_idx_o <= peak_q;
            state_q <= ST_IDLE;
          end else begin
            s_prev_q   <= rd_data;
            scan_idx_q <= scan_idx_q - 1'b1;
          end
        end
        ST_DIV: if (div_done) begin
          done_o <= 1'b1; err_o <= 1'b0; time_valid_o <= 1'b1;
          time_o <= {scan_idx_q, FRAC_W'(0)} + TIME_W'(div_q);
          amp_o <= amp_q; peak_idx_o <= peak_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfd_timer_chk.sv
module cfd_timer_chk #(
  parameter int IDX_W  = 10,
  parameter int TIME_W = 18,
  parameter int FRAC_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ready_o,
  input logic              done_o,
  input logic              time_valid_o,
  input logic              err_o,
  input logic [IDX_W-1:0]  peak_idx_o,
  input logic [TIME_W-1:0] time_o
);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ready_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  p_start_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> !ready_o);

  p_flag_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (time_valid_o != err_o));

  p_err_time_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (time_o == '0));

  p_time_before_peak_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && time_valid_o) |-> (time_o <= {peak_idx_o, FRAC_W'(0)}));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(time_o));
endmodule

bind cfd_timer cfd_timer_chk #(.IDX_W(IDX_W), .TIME_W(TIME_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_o(ready_o),
  .done_o(done_o), .time_valid_o(time_valid_o), .err_o(err_o),
  .peak_idx_o(peak_idx_o), .time_o(time_o)
);

// File: tb/sim_cfd_timer.sv
module sim_cfd_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam int WD_LIMIT = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  k_i = '0;
  logic [11:0] min_amp_i = '0;
  logic [11:0] sample_i = '0;
  logic        sample_vld_i = 1'b0;
  logic        ready_o, done_o, time_valid_o, err_o;
  logic [11:0] amp_o;
  logic [9:0]  peak_idx_o;
  logic [17:0] time_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int wave [DEPTH];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cfd_timer u0 (.*);

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      errors++; checks++;
      $display("FAIL watchdog R7: act=%0d exp<=%0d", cycles, WD_LIMIT);
      report();
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic flat(int lvl);
    for (int j = 0; j < DEPTH; j++) wave[j] = lvl;
  endtask

  task automatic tri_pulse(int pos, int rise, int fall, int h);
    for (int j = pos - rise; j <= pos + fall; j++) begin
      int v;
      if (j < 0 || j >= DEPTH) continue;
      v = (j <= pos) ? h * (j - pos + rise) / rise : h * (pos + fall - j) / fall;
      wave[j] = wave[j] + v;
      if (wave[j] > 4095) wave[j] = 4095;
    end
  endtask

  // gaps: drop sample_vld_i now and then; poke: pulse start_i during load
  task automatic run(int k, int mina, bit gaps, bit poke, string tag);
    int base, mx, pk, amp, thr, lat, ei, q, tm;
    bit err;
    base = 0;
    for (int j = 0; j < 16; j++) base += wave[j];
    base = base / 16;
    mx = wave[0]; pk = 0;
    for (int j = 1; j < DEPTH; j++) if (wave[j] > mx) begin mx = wave[j]; pk = j; end
    amp = mx - base;
    thr = base + (amp * k) / 256;
    err = 0; tm = 0; ei = -1;
    if (amp < mina || pk == 0) begin err = 1; lat = 1; end
    else begin
      for (int j = pk - 1; j >= 0; j--) if (wave[j] < thr) begin ei = j; break; end
      if (ei < 0) begin err = 1; lat = 1 + pk; end
      else begin
        q = ((thr - wave[ei]) * 256) / (wave[ei+1] - wave[ei]);
        tm = ei * 256 + q;
        lat = 11 + (pk - ei);
      end
    end

    @(negedge clk_i);
    chk(ready_o == 1'b1, {tag, " R8 ready before start"}, int'(ready_o), 1);
    k_i = 8'(k); min_amp_i = 12'(mina); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(ready_o == 1'b0, {tag, " R8 busy after start"}, int'(ready_o), 0);
    k_i = 8'(k + 37); min_amp_i = 12'(mina + 999);
    for (int j = 0; j < DEPTH; j++) begin
      if (gaps && (j % 97 == 5)) begin
        sample_vld_i = 1'b0; sample_i = 12'hFFF;
        @(negedge clk_i);
      end
      sample_i = 12'(wave[j]); sample_vld_i = 1'b1;
      start_i = poke && (j == 300);
      @(negedge clk_i);
      if (poke && j == 300)
        chk(ready_o == 1'b0 && done_o == 1'b0, {tag, " R8 start ignored"}, int'(ready_o), 0);
    end
    sample_vld_i = 1'b0; start_i = 1'b0; sample_i = '0;
    for (int c = 1; c <= lat + 2; c++) begin
      @(negedge clk_i);
      chk(done_o == (c == lat), {tag, " R7 done timing"}, int'(done_o), int'(c == lat));
      chk(ready_o == (c >= lat), {tag, " R8 ready return"}, int'(ready_o), int'(c >= lat));
      if (c == lat) begin
        chk(amp_o == 12'(amp), {tag, " R2 amplitude"}, int'(amp_o), amp);
        chk(peak_idx_o == 10'(pk), {tag, " R3 peak index"}, int'(peak_idx_o), pk);
        chk(err_o == err, {tag, " R6 error flag"}, int'(err_o), int'(err));
        chk(time_valid_o == !err, {tag, " R6 valid flag"}, int'(time_valid_o), int'(!err));
        chk(time_o == 18'(tm), {tag, " R5 R4 crossing time"}, int'(time_o), tm);
      end
    end
    repeat (3) @(negedge clk_i);
    chk(time_o == 18'(tm), {tag, " R9 result held"}, int'(time_o), tm);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o == 1'b1, "R1 ready", int'(ready_o), 1);
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    chk(time_valid_o == 1'b0, "R1 valid", int'(time_valid_o), 0);
    chk(err_o == 1'b0, "R1 err", int'(err_o), 0);

    flat(300); tri_pulse(400, 20, 60, 1500);
    run(77, 50, 1, 1, "A");
    flat(300); tri_pulse(400, 20, 60, 600);
    run(77, 50, 0, 0, "B");
    flat(150); tri_pulse(900, 7, 40, 3000);
    run(200, 50, 1, 0, "C");
    flat(500); tri_pulse(600, 10, 10, 30);
    run(128, 50, 0, 0, "D min amplitude");
    flat(100); wave[0] = 2000;
    run(128, 10, 0, 0, "E peak at zero");
    flat(100); wave[500] = 200; wave[501] = 356; wave[502] = 612;
    wave[503] = 400; wave[504] = 150;
    run(128, 10, 0, 0, "F exact level");
    flat(100); tri_pulse(200, 12, 12, 900);
    run(0, 10, 0, 0, "G k zero");
    flat(250); tri_pulse(300, 9, 9, 1800); tri_pulse(700, 4, 9, 1800);
    run(255, 10, 1, 0, "H tie first");
    flat(250); tri_pulse(50, 30, 30, 1000);
    run(1, 10, 0, 0, "I small k");
    report();
  end
endmodule